// File: doc/BRIEF.md
# Legacy BIOS Shadow Region Decoder

This block sits on the processor memory path and decides who answers an access in the upper legacy window, from C0000h up to FFFFFh. It chooses between main memory and the bus bridge. The window is split into twelve segments, and each segment has a 2-bit attribute. A read and a write to the same address can therefore go to different targets. This is how a boot image is shadowed: it is fetched from the bridge while it is copied into memory, and it is later run from memory with writes blocked.

The decision is combinational from the access inputs and the current attributes. Attributes are loaded through a one-segment-per-cycle configuration write port. A role strap, sampled during reset, selects whether the topmost 64 Kbyte boot segment comes out of reset fully enabled. It is enabled on the primary bridge so that the first instruction fetches are answered, and it is disabled on every other device. Addresses outside the window produce no decision from this block.

Top module: `shadow_region_decoder`

## Requirements
- R1: An access with an address below C0000h, or at or above 100000h, asserts neither mem_claim nor bridge_fwd.
- R2: While acc_valid is low, neither mem_claim nor bridge_fwd is asserted.
- R3: A valid access inside C0000h–FFFFFh asserts exactly one of mem_claim and bridge_fwd.
- R4: Attribute bit 0 lets reads reach memory and bit 1 lets writes reach memory. The codes are 00 disabled, 01 read-only, 10 write-only and 11 read/write. An in-window access claims memory when its direction bit is set and is forwarded to the bridge otherwise.
- R5: The segments are numbered as follows. Segment 0 covers C0000h–C7FFFh. Segments 1 to 6 cover C8000h–DFFFFh in ascending 16 Kbyte steps. Segments 7 to 10 cover E0000h–EFFFFh in ascending 16 Kbyte steps. Segment 11 covers F0000h–FFFFFh.
- R6: After reset, segments 0 to 10 are disabled. Segment 11 is read/write (11) when boot_primary is high during reset, and disabled (00) when it is low.
- R7: A cycle with cfg_we high and cfg_idx below 12 loads cfg_attr into segment cfg_idx from the next cycle on. All other segments keep their values.
- R8: A configuration write with cfg_idx from 12 to 15 changes no segment.
- R9: Changes on boot_primary after reset has been released have no effect on any segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_primary | input | 1 | Role strap, sampled while in reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Segment number to write |
| cfg_attr | input | 2 | Attribute value to write |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Access byte address |
| mem_claim | output | 1 | Main memory answers the access |
| bridge_fwd | output | 1 | Access is forwarded to the bridge |

## Verification
The bench builds the block with its defaults: a 32-bit address and twelve segments. Because the window is only 256 Kbyte, every 16 Kbyte granule from 0 to 11FFFFh can be probed at its first and last byte, for both reads and writes. It repeats this under several rotating attribute patterns and under both strap values. This covers every segment edge, every attribute code in every segment, both out-of-window margins, the ignored high indices and a strap toggle after reset.

// File: rtl/shadow_pkg.sv
package shadow_pkg;

  localparam int SEG_CNT   = 12;
  localparam int SEG_IDX_W = $clog2(SEG_CNT);
  localparam int BOOT_SEG  = SEG_CNT - 1;

  typedef logic [1:0] seg_attr_t;
  typedef logic [SEG_IDX_W-1:0] seg_idx_t;

  localparam seg_attr_t ATTR_OFF = 2'b00;
  localparam seg_attr_t ATTR_RO  = 2'b01;
  localparam seg_attr_t ATTR_WO  = 2'b10;
  localparam seg_attr_t ATTR_RW  = 2'b11;

  localparam logic [63:0] WIN_LO   = 64'h000C_0000;
  localparam logic [63:0] WIN_HI   = 64'h0010_0000;
  localparam logic [63:0] GRAN_SZ  = 64'h0000_4000;

  // Lower bound of segment s; segment 0 spans two granules, the last spans four.
  function automatic logic [63:0] seg_base(input int s);
    logic [63:0] steps;
    steps = (s == 0) ? 64'd0 : 64'(s + 1);
    return WIN_LO + steps * GRAN_SZ;
  endfunction

  function automatic logic in_window(input logic [63:0] a);
    return (a >= WIN_LO) && (a < WIN_HI);
  endfunction

  function automatic seg_idx_t seg_of(input logic [63:0] a);
    seg_idx_t idx;
    idx = '0;
    for (int s = 1; s < SEG_CNT; s++) begin
      if (a >= seg_base(s)) idx = seg_idx_t'(s);
    end
    return idx;
  endfunction

  function automatic logic dir_enabled(input seg_attr_t at, input logic is_wr);
    return is_wr ? at[1] : at[0];
  endfunction

endpackage

// File: rtl/shadow_seg_decode.sv
module shadow_seg_decode
  import shadow_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output seg_idx_t          seg
);
  logic [63:0] addr_ext;

  always_comb begin
    addr_ext = 64'(addr);
    hit      = in_window(addr_ext);
    seg      = seg_of(addr_ext);
  end
endmodule

// File: rtl/shadow_attr_bank.sv
module shadow_attr_bank
  import shadow_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     boot_primary,
  input  logic                     cfg_we,
  input  seg_idx_t                 cfg_idx,
  input  seg_attr_t                cfg_attr,
  output logic [SEG_CNT-1:0][1:0]  attr_vec
);
  logic cfg_in_range;
  assign cfg_in_range = (int'(cfg_idx) < SEG_CNT);

  for (genvar s = 0; s < SEG_CNT; s++) begin : g_seg
    seg_attr_t slot_q;
    seg_attr_t reset_val;
    logic      sel;

    if (s == BOOT_SEG) begin : g_boot
      assign reset_val = boot_primary ? ATTR_RW : ATTR_OFF;
    end else begin : g_plain
      assign reset_val = ATTR_OFF;
    end

    assign sel = cfg_we && (cfg_idx == seg_idx_t'(s));

    always_ff @(posedge clk) begin
      if (!rst_n)   slot_q <= reset_val;
      else if (sel) slot_q <= cfg_attr;
    end

    assign attr_vec[s] = slot_q;
  end

  // R7: a legal write lands in its slot one cycle later
  assert_cfg_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_in_range) |=> (attr_vec[$past(cfg_idx)] == $past(cfg_attr)));

  // R8: out-of-range index leaves every slot alone
  assert_bad_idx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_in_range) |=> $stable(attr_vec));

  // R9: with no write the bank holds, whatever the strap does
  assert_strap_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(attr_vec));

  // R6: reset defaults as seen on release
  assert_boot_default_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (attr_vec[BOOT_SEG] == ($past(boot_primary) ? ATTR_RW : ATTR_OFF))
                     && (attr_vec[0] == ATTR_OFF));
endmodule

// File: rtl/shadow_claim.sv
module shadow_claim
  import shadow_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     acc_valid,
  input  logic                     acc_write,
  input  logic                     hit,
  input  seg_idx_t                 seg,
  input  logic [SEG_CNT-1:0][1:0]  attr_vec,
  output logic                     mem_claim,
  output logic                     bridge_fwd
);
  seg_attr_t sel_attr;
  logic      dir_ok;
  logic      live;

  always_comb begin
    sel_attr = ATTR_OFF;
    for (int s = 0; s < SEG_CNT; s++) begin
      if (seg == seg_idx_t'(s)) sel_attr = attr_vec[s];
    end
    dir_ok     = dir_enabled(sel_attr, acc_write);
    live       = acc_valid && hit;
    mem_claim  = live && dir_ok;
    bridge_fwd = live && !dir_ok;
  end

  assert_one_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_claim && bridge_fwd));

  assert_window_answered_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && hit) |-> (mem_claim || bridge_fwd));

  assert_outside_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (!mem_claim && !bridge_fwd));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (!mem_claim && !bridge_fwd));
endmodule

// File: rtl/shadow_region_decoder.sv
module shadow_region_decoder
  import shadow_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_primary,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_idx,
  input  logic [1:0]        cfg_attr,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              mem_claim,
  output logic              bridge_fwd
);
  logic                    dec_hit;
  seg_idx_t                dec_seg;
  logic [SEG_CNT-1:0][1:0] attr_vec;

  shadow_seg_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (acc_addr),
    .hit  (dec_hit),
    .seg  (dec_seg)
  );

  shadow_attr_bank u_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .boot_primary (boot_primary),
    .cfg_we       (cfg_we),
    .cfg_idx      (seg_idx_t'(cfg_idx)),
    .cfg_attr     (cfg_attr),
    .attr_vec     (attr_vec)
  );

  shadow_claim u_claim (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .hit        (dec_hit),
    .seg        (dec_seg),
    .attr_vec   (attr_vec),
    .mem_claim  (mem_claim),
    .bridge_fwd (bridge_fwd)
  );

  initial begin
    assert_addr_width_R1: assert (ADDR_W >= 21 && ADDR_W <= 64);
  end
endmodule

// File: tb/shadow_region_decoder_bench.sv
module shadow_region_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NSEG = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_primary = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [1:0]  cfg_attr = '0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        mem_claim, bridge_fwd;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [1:0] mdl [NSEG];

  always #(CLK_PERIOD/2) clk = ~clk;

  shadow_region_decoder u_shadow_region_decoder (
    .clk(clk), .rst_n(rst_n), .boot_primary(boot_primary),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_attr(cfg_attr),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .mem_claim(mem_claim), .bridge_fwd(bridge_fwd)
  );

  function automatic int ref_seg(input longint a);
    if (a < 'hC8000) return 0;
    if (a >= 'hF0000) return 11;
    return int'((a - 'hC8000) / 'h4000) + 1;
  endfunction

  task automatic check(input string tag, input logic got_m, input logic got_b,
                       input logic exp_m, input logic exp_b, input longint a);
    checks++;
    if (got_m !== exp_m || got_b !== exp_b) begin
      failures++;
      $display("FAIL %s addr=%h got mem=%b br=%b expected mem=%b br=%b",
               tag, a, got_m, got_b, exp_m, exp_b);
    end
  endtask

  task automatic probe(input longint a, input logic wr, input logic vld, input string tag);
    bit inw;
    logic em, eb, ok;
    @(negedge clk);
    acc_addr = 32'(a); acc_write = wr; acc_valid = vld;
    #1;
    inw = (a >= 'hC0000) && (a < 'h100000);
    ok  = inw ? (wr ? mdl[ref_seg(a)][1] : mdl[ref_seg(a)][0]) : 1'b0;
    em  = vld && inw && ok;
    eb  = vld && inw && !ok;
    check(inw ? tag : "R1", mem_claim, bridge_fwd, em, eb, a);
    acc_valid = 1'b0;
  endtask

  task automatic sweep(input string tag);
    for (int g = 0; g < 72; g++) begin
      for (int e = 0; e < 2; e++) begin
        longint a;
        a = longint'(g) * 'h4000 + (e == 0 ? 0 : 'h3FFF);
        probe(a, 1'b0, 1'b1, tag);
        probe(a, 1'b1, 1'b1, tag);
      end
    end
    probe('hFFFF_FFFF, 1'b0, 1'b1, "R1");
    probe('hBFFFF, 1'b1, 1'b1, "R1");
  endtask

  task automatic do_reset(input logic role);
    @(negedge clk);
    rst_n = 1'b0; boot_primary = role;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int s = 0; s < NSEG; s++) mdl[s] = 2'b00;
    mdl[11] = role ? 2'b11 : 2'b00;
  endtask

  task automatic cfg(input int idx, input logic [1:0] at);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_attr = at;
    @(negedge clk);
    cfg_we = 1'b0;
    if (idx < NSEG) mdl[idx] = at;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R6: reset defaults, secondary role
    do_reset(1'b0);
    probe('hF0000, 1'b0, 1'b1, "R6");
    probe('hFFFFF, 1'b1, 1'b1, "R6");
    sweep("R6");
    // R6: primary role boots with the top segment enabled
    do_reset(1'b1);
    probe('hF0000, 1'b0, 1'b1, "R6");
    probe('hEFFFF, 1'b0, 1'b1, "R6");
    sweep("R6");
    // R9: strap toggles after release are ignored
    boot_primary = 1'b0;
    repeat (3) @(negedge clk);
    probe('hF8000, 1'b0, 1'b1, "R9");
    probe('hF8000, 1'b1, 1'b1, "R9");
    // R4/R5/R7: rotating attribute patterns across every segment
    for (int k = 0; k < 4; k++) begin
      for (int s = 0; s < NSEG; s++) cfg(s, 2'((s + k) % 4));
      sweep("R4/R5/R7");
    end
    // R2: invalid accesses stay quiet even where memory would claim
    for (int s = 0; s < NSEG; s++) cfg(s, 2'b11);
    probe('hC4000, 1'b0, 1'b0, "R2");
    probe('hE8000, 1'b1, 1'b0, "R2");
    probe('hFFFFF, 1'b0, 1'b0, "R2");
    // R8: out-of-range indices change nothing
    for (int s = 0; s < NSEG; s++) cfg(s, 2'b00);
    for (int i = 12; i < 16; i++) cfg(i, 2'b11);
    sweep("R8");
    // R7: single write touches only its own segment
    cfg(7, 2'b10);
    probe('hE0000, 1'b1, 1'b1, "R7");
    probe('hE0000, 1'b0, 1'b1, "R7");
    probe('hE4000, 1'b1, 1'b1, "R7");
    probe('hDFFFF, 1'b1, 1'b1, "R7");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule